// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Controller

This block is the slave side of a page-organised serial flash. It sits behind a four-wire serial port: select, clock, data in and data out. Two page-sized SRAM buffers stand in front of a small main array. A host fills either buffer, reads it back, copies a main page into a buffer, or programs a buffer into a main page. Every command begins with one opcode byte. Most commands then carry three address bytes. All bytes travel most significant bit first, in clock mode 0 or mode 3.

Page copies between a buffer and the array are self-timed. A cycle counter on the system clock times them, and the ready output stays low for the whole operation. During that time the buffer tied to the operation is locked. Reads and writes to the other buffer still proceed, so a host can load the next page while the previous one is being programmed. The page length is 512 or 528 bytes and is chosen by a configuration input. The number of main pages, the program time and the transfer time are parameters.

Top module: `dbf_flash_ctrl`

## Requirements
- R1: Opcode 84h writes buffer 1 and 87h writes buffer 2. The opcode is followed by three address bytes, sent high byte first. The data bytes that follow are stored at consecutive byte positions, starting at the addressed byte. In 512-byte mode the byte address is address bits 8:0 and the page number starts at bit 9.
- R2: Opcodes D1h (buffer 1) and D3h (buffer 2) send buffer data right after the address. D4h (buffer 1) and D6h (buffer 2) expect one dummy byte first. Data leaves MSB first, changes after falling clock edges, and is driven (so_oe high) only in the data phase. A rising select ends the read and drops so_oe.
- R3: During a continuous buffer write or read, the position after the last byte of the page (511, or 527 in 528-byte mode) is byte 0.
- R4: Opcode 83h (buffer 1) or 86h (buffer 2), with three complete address bytes, starts a program when select rises. The program copies the whole buffer into the addressed main page. ready is low for exactly PROG_CYCLES system clocks.
- R5: Opcode 53h (buffer 1) or 55h (buffer 2), with three complete address bytes, starts a transfer when select rises. The transfer copies the addressed main page into the buffer. ready is low for exactly XFER_CYCLES system clocks.
- R6: Opcode D7h returns a status byte repeatedly for as long as select stays low. Bit 7 is 1 when ready and 0 while busy; all other bits are 0.
- R7: While a program or transfer runs, buffer writes and reads that name the other buffer are carried out. Commands that name the locked buffer, and any further program or transfer, are ignored and change no state.
- R8: Undefined opcodes are ignored. A program or transfer whose select rises before its third address byte has arrived starts nothing.
- R9: In 528-byte mode a page holds 528 bytes. The byte address is address bits 9:0 and the page number starts at bit 10.
- R10: After reset, ready is high and so_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| page_ext | input | 1 | 1 selects 528-byte pages, 0 selects 512-byte pages |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for so; low means so is released |
| ready | output | 1 | High when no self-timed operation is running |

## Verification
The assertions check on every cycle that:
- a locked buffer is never written;
- a new array operation never starts while one is running;
- the locked buffer does not change during an operation;
- the byte pointer stays inside the page;
- the byte strobe is a single-cycle pulse.

Only the bench scenarios can show the data itself: bytes landing at the right addresses, wrap-around at both page lengths, the dummy-byte read forms, mode 3 clocking, exact busy lengths, and ignored commands leaving buffer contents untouched.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;
    localparam int IDX_W    = 10;
    localparam int PLEN_STD = 512;
    localparam int PLEN_EXT = 528;
    localparam int PLEN_MAX = PLEN_EXT;

    localparam logic [7:0] OP_STATUS = 8'hD7;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_WDATA, ST_RDATA, ST_STAT, ST_ARMED
    } st_e;

    typedef enum logic [1:0] {K_WRITE, K_READ, K_PROG, K_XFER} kind_e;

    typedef struct packed {
        kind_e kind;
        logic  bsel;
        logic  dummy;
    } cmd_t;

    function automatic idx_t last_idx(input logic ext);
        return ext ? idx_t'(PLEN_EXT - 1) : idx_t'(PLEN_STD - 1);
    endfunction

    function automatic idx_t next_idx(input idx_t i, input logic ext);
        return (i == last_idx(ext)) ? '0 : i + idx_t'(1);
    endfunction

    function automatic logic op_decode(input logic [7:0] op, output cmd_t c);
        c = '{kind: K_WRITE, bsel: 1'b0, dummy: 1'b0};
        op_decode = 1'b1;
        case (op)
            8'h84: c.kind = K_WRITE;
            8'h87: begin c.kind = K_WRITE; c.bsel = 1'b1; end
            8'h83: c.kind = K_PROG;
            8'h86: begin c.kind = K_PROG; c.bsel = 1'b1; end
            8'h53: c.kind = K_XFER;
            8'h55: begin c.kind = K_XFER; c.bsel = 1'b1; end
            8'hD1: c.kind = K_READ;
            8'hD3: begin c.kind = K_READ; c.bsel = 1'b1; end
            8'hD4: begin c.kind = K_READ; c.dummy = 1'b1; end
            8'hD6: begin c.kind = K_READ; c.bsel = 1'b1; c.dummy = 1'b1; end
            default: op_decode = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dbf_spi_port.sv
`timescale 1ns/1ps
module dbf_spi_port (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    input  logic       tx_en,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic       so,
    output logic       so_oe
);
    logic [1:0] cs_s, sck_s, si_s;
    logic       cs_q, sck_q;
    logic [2:0] bit_cnt;
    logic [7:0] in_sh, out_sh;
    logic       so_r, stb_r;
    logic       sel, sck_up, sck_dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_s  <= 2'b11;
            sck_s <= 2'b00;
            si_s  <= 2'b00;
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_s  <= {cs_s[0], cs_n};
            sck_s <= {sck_s[0], sck};
            si_s  <= {si_s[0], si};
            cs_q  <= cs_s[1];
            sck_q <= sck_s[1];
        end
    end

    assign sel     = ~cs_s[1];
    assign sck_up  = sck_s[1] & ~sck_q;
    assign sck_dn  = ~sck_s[1] & sck_q;
    assign cs_fall = cs_q & ~cs_s[1];
    assign cs_rise = ~cs_q & cs_s[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            in_sh   <= '0;
            stb_r   <= 1'b0;
        end else begin
            stb_r <= 1'b0;
            if (cs_fall) begin
                bit_cnt <= '0;
            end else if (sel && sck_up) begin
                in_sh   <= {in_sh[6:0], si_s[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) stb_r <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sh <= '0;
            so_r   <= 1'b0;
        end else if (tx_load) begin
            out_sh <= tx_byte;
        end else if (sel && sck_dn) begin
            so_r   <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
        end
    end

    assign byte_stb = stb_r;
    assign byte_val = in_sh;
    assign so       = so_r;
    assign so_oe    = sel & tx_en;

    // R2: each received byte is announced by a one-cycle strobe
    a_r2_stb_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);
endmodule

// File: rtl/dbf_cmd_ctrl.sv
`timescale 1ns/1ps
module dbf_cmd_ctrl
    import dbf_pkg::*;
#(
    parameter int PAGE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_ext,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              byte_stb,
    input  logic [7:0]        byte_val,
    input  logic              busy,
    input  logic              busy_buf,
    input  logic [7:0]        rd_data,
    output logic              rd_buf,
    output idx_t              rd_idx,
    output logic              wr_en,
    output logic              wr_buf,
    output idx_t              wr_idx,
    output logic [7:0]        wr_data,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic              tx_en,
    output logic              go,
    output logic              go_prog,
    output logic              go_buf,
    output logic [PAGE_W-1:0] go_page
);
    st_e         state;
    cmd_t        cmd, dec;
    logic [1:0]  acnt;
    logic [15:0] ash;
    idx_t        ptr, start_idx;
    logic        fetch, dec_ok, op_ok;
    logic [23:0] addr24;
    logic [PAGE_W-1:0] page_sel;
    logic [7:0]  stat;

    always_comb begin
        dec_ok = op_decode(byte_val, dec);
        if (dec.kind == K_PROG || dec.kind == K_XFER)
            op_ok = dec_ok && !busy;
        else
            op_ok = dec_ok && !(busy && busy_buf == dec.bsel);
    end

    always_comb begin
        addr24 = {ash, byte_val};
        if (page_ext) begin
            start_idx = addr24[9:0];
            if (start_idx > last_idx(1'b1)) start_idx = '0;
            page_sel = addr24[10 +: PAGE_W];
        end else begin
            start_idx = {1'b0, addr24[8:0]};
            page_sel  = addr24[9 +: PAGE_W];
        end
    end

    assign stat = {~busy, 7'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cmd     <= '{kind: K_WRITE, bsel: 1'b0, dummy: 1'b0};
            acnt    <= '0;
            ash     <= '0;
            ptr     <= '0;
            fetch   <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            tx_load <= 1'b0;
            tx_byte <= '0;
            go      <= 1'b0;
            go_page <= '0;
        end else begin
            wr_en   <= 1'b0;
            tx_load <= 1'b0;
            go      <= 1'b0;
            fetch   <= 1'b0;
            if (fetch) begin
                tx_load <= 1'b1;
                if (state == ST_STAT) begin
                    tx_byte <= stat;
                end else begin
                    tx_byte <= rd_data;
                    ptr     <= next_idx(ptr, page_ext);
                end
            end
            if (cs_fall) begin
                state <= ST_OPC;
            end else if (cs_rise) begin
                if (state == ST_ARMED && !busy) go <= 1'b1;
                state <= ST_IDLE;
            end else if (byte_stb) begin
                case (state)
                    ST_OPC: begin
                        if (op_ok) begin
                            cmd   <= dec;
                            acnt  <= '0;
                            state <= ST_ADDR;
                        end else if (byte_val == OP_STATUS) begin
                            state <= ST_STAT;
                            fetch <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_ADDR: begin
                        ash  <= {ash[7:0], byte_val};
                        acnt <= acnt + 2'd1;
                        if (acnt == 2'd2) begin
                            ptr     <= start_idx;
                            go_page <= page_sel;
                            case (cmd.kind)
                                K_WRITE: state <= ST_WDATA;
                                K_READ: begin
                                    if (cmd.dummy) begin
                                        state <= ST_DUMMY;
                                    end else begin
                                        state <= ST_RDATA;
                                        fetch <= 1'b1;
                                    end
                                end
                                default: state <= ST_ARMED;
                            endcase
                        end
                    end
                    ST_DUMMY: begin
                        state <= ST_RDATA;
                        fetch <= 1'b1;
                    end
                    ST_WDATA: begin
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr;
                        wr_data <= byte_val;
                        ptr     <= next_idx(ptr, page_ext);
                    end
                    ST_RDATA, ST_STAT: fetch <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign rd_buf  = cmd.bsel;
    assign rd_idx  = ptr;
    assign wr_buf  = cmd.bsel;
    assign go_buf  = cmd.bsel;
    assign go_prog = (cmd.kind == K_PROG);
    assign tx_en   = (state == ST_RDATA) || (state == ST_STAT);

    // R7: the buffer locked by a running operation is never written
    a_r7_no_write_locked: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !(busy && wr_buf == busy_buf));
    // R3: the data pointer never leaves the page
    a_r3_ptr_in_page: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA || state == ST_RDATA) |-> ptr <= last_idx(page_ext));
    // R8: an array operation is launched only when the array is idle
    a_r8_go_when_idle: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);
endmodule

// File: rtl/dbf_store.sv
`timescale 1ns/1ps
module dbf_store
    import dbf_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int PAGE_W      = 2,
    parameter int PROG_CYCLES = 1200,
    parameter int XFER_CYCLES = 600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_ext,
    input  logic              rd_buf,
    input  idx_t              rd_idx,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic              wr_buf,
    input  idx_t              wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              go,
    input  logic              go_prog,
    input  logic              go_buf,
    input  logic [PAGE_W-1:0] go_page,
    output logic              busy,
    output logic              busy_buf
);
    localparam int BUF_N  = 2 * PLEN_MAX;
    localparam int ARR_N  = PAGES * PLEN_MAX;
    localparam int BUF_AW = $clog2(BUF_N);
    localparam int ARR_AW = $clog2(ARR_N);
    localparam int CMAX   = (PROG_CYCLES > XFER_CYCLES) ? PROG_CYCLES : XFER_CYCLES;
    localparam int CNT_W  = $clog2(CMAX + 1);

    logic [7:0] bufm [BUF_N];
    logic [7:0] arr  [ARR_N];

    logic              e_prog, e_ext;
    logic [PAGE_W-1:0] e_page;
    logic [CNT_W-1:0]  cnt, total, len;
    logic              copy_on;
    idx_t              cidx;
    logic [BUF_AW-1:0] ra, wa, xa;
    logic [ARR_AW-1:0] aa;

    assign total   = e_prog ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(XFER_CYCLES - 1);
    assign len     = e_ext ? CNT_W'(PLEN_EXT) : CNT_W'(PLEN_STD);
    assign copy_on = busy && (cnt < len);
    assign cidx    = cnt[IDX_W-1:0];

    assign ra = BUF_AW'(rd_buf) * BUF_AW'(PLEN_MAX) + BUF_AW'(rd_idx);
    assign wa = BUF_AW'(wr_buf) * BUF_AW'(PLEN_MAX) + BUF_AW'(wr_idx);
    assign xa = BUF_AW'(busy_buf) * BUF_AW'(PLEN_MAX) + BUF_AW'(cidx);
    assign aa = ARR_AW'(e_page) * ARR_AW'(PLEN_MAX) + ARR_AW'(cidx);

    assign rd_data = bufm[ra];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            busy_buf <= 1'b0;
            e_prog   <= 1'b0;
            e_ext    <= 1'b0;
            e_page   <= '0;
            cnt      <= '0;
        end else if (go) begin
            busy     <= 1'b1;
            busy_buf <= go_buf;
            e_prog   <= go_prog;
            e_ext    <= page_ext;
            e_page   <= go_page;
            cnt      <= '0;
        end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == total) busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) bufm[wa] <= wr_data;
        if (copy_on && !e_prog) bufm[xa] <= arr[aa];
        if (copy_on && e_prog) arr[aa] <= bufm[xa];
    end

    // R7: no second operation starts on top of a running one
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);
    // R4: the locked buffer does not change mid-operation
    a_r4_buf_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !go) |=> (!busy || $stable(busy_buf)));
endmodule

// File: rtl/dbf_flash_ctrl.sv
`timescale 1ns/1ps
module dbf_flash_ctrl
    import dbf_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int PROG_CYCLES = 1200,
    parameter int XFER_CYCLES = 600
) (
    input  logic clk,
    input  logic rst,
    input  logic page_ext,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe,
    output logic ready
);
    localparam int PAGE_W = (PAGES > 1) ? $clog2(PAGES) : 1;

    logic              cs_fall, cs_rise, byte_stb;
    logic [7:0]        byte_val, tx_byte, rd_data, wr_data;
    logic              tx_load, tx_en;
    logic              busy, busy_buf;
    logic              rd_buf, wr_en, wr_buf;
    idx_t              rd_idx, wr_idx;
    logic              go, go_prog, go_buf;
    logic [PAGE_W-1:0] go_page;

    dbf_spi_port u_port (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .tx_load(tx_load), .tx_byte(tx_byte), .tx_en(tx_en),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .byte_stb(byte_stb),
        .byte_val(byte_val), .so(so), .so_oe(so_oe)
    );

    dbf_cmd_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
        .clk(clk), .rst(rst), .page_ext(page_ext),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .byte_stb(byte_stb),
        .byte_val(byte_val), .busy(busy), .busy_buf(busy_buf),
        .rd_data(rd_data), .rd_buf(rd_buf), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_data(wr_data),
        .tx_load(tx_load), .tx_byte(tx_byte), .tx_en(tx_en),
        .go(go), .go_prog(go_prog), .go_buf(go_buf), .go_page(go_page)
    );

    dbf_store #(
        .PAGES(PAGES), .PAGE_W(PAGE_W),
        .PROG_CYCLES(PROG_CYCLES), .XFER_CYCLES(XFER_CYCLES)
    ) u_store (
        .clk(clk), .rst(rst), .page_ext(page_ext),
        .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_buf(wr_buf), .wr_idx(wr_idx), .wr_data(wr_data),
        .go(go), .go_prog(go_prog), .go_buf(go_buf), .go_page(go_page),
        .busy(busy), .busy_buf(busy_buf)
    );

    assign ready = ~busy;
endmodule

// File: tb/dbf_flash_ctrl_tb.sv
`timescale 1ns/1ps
module dbf_flash_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;
    localparam int PROG       = 20000;
    localparam int XFER       = 2000;

    logic clk = 1'b0, rst = 1'b1, page_ext = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, cpol = 1'b0;
    logic so, so_oe, ready;

    dbf_flash_ctrl #(.PAGES(4), .PROG_CYCLES(PROG), .XFER_CYCLES(XFER)) u_dut (
        .clk(clk), .rst(rst), .page_ext(page_ext), .cs_n(cs_n), .sck(sck),
        .si(si), .so(so), .so_oe(so_oe), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0, busy_cnt = 0;
    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] rx_q[$];

    always @(negedge clk) if (!ready) busy_cnt++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // scoreboard monitor: pairs received bytes with expected ones
    initial begin
        forever begin
            wait (rx_q.size() > 0);
            begin
                logic [7:0] got;
                exp_t e;
                got = rx_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard underflow", int'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got === e.v, e.tag, int'(got), int'(e.v));
                end
            end
        end
    end

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            si  = tx[i];
            #(HALF);
            rx[i] = so;
            sck = 1'b1;
            #(HALF);
        end
    endtask

    task automatic spi_open();
        sck  = cpol;
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic spi_close();
        sck = cpol;
        #(HALF);
        cs_n = 1'b1;
        #(4*HALF);
    endtask

    task automatic hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xbyte(op, r);
        xbyte(a[23:16], r);
        xbyte(a[15:8], r);
        xbyte(a[7:0], r);
    endtask

    task automatic wr_buf(input logic [7:0] op, input logic [23:0] a,
                          input int n, input logic [63:0] d);
        logic [7:0] r;
        spi_open();
        hdr(op, a);
        for (int i = 0; i < n; i++) xbyte(d[63-8*i -: 8], r);
        spi_close();
    endtask

    task automatic rd_buf(input logic [7:0] op, input logic [23:0] a, input bit dummy,
                          input int n, input logic [63:0] d, input string tag);
        logic [7:0] r;
        for (int i = 0; i < n; i++) exp_q.push_back('{v: d[63-8*i -: 8], tag: tag});
        spi_open();
        hdr(op, a);
        if (dummy) xbyte(8'h00, r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'hFF, r);
            rx_q.push_back(r);
        end
        spi_close();
        wait (rx_q.size() == 0);
        chk(so_oe == 1'b0, "R2 so_oe released after select rises", int'(so_oe), 0);
    endtask

    task automatic rd_status(input logic [7:0] exp, input string tag);
        logic [7:0] r;
        exp_q.push_back('{v: exp, tag: tag});
        exp_q.push_back('{v: exp, tag: tag});
        spi_open();
        xbyte(8'hD7, r);
        for (int i = 0; i < 2; i++) begin
            xbyte(8'hFF, r);
            rx_q.push_back(r);
        end
        spi_close();
        wait (rx_q.size() == 0);
    endtask

    task automatic short_cmd(input logic [7:0] op, input int nb);
        logic [7:0] r;
        spi_open();
        xbyte(op, r);
        for (int i = 0; i < nb; i++) xbyte(8'h00, r);
        spi_close();
    endtask

    task automatic wait_ready();
        wait (ready == 1'b1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R10 ready after reset", int'(ready), 1);
        chk(so_oe == 1'b0, "R10 so_oe after reset", int'(so_oe), 0);

        // R1 write then R2 read without and with dummy byte
        wr_buf(8'h84, 24'h000005, 5, 64'h1122334455_000000);
        rd_buf(8'hD1, 24'h000005, 1'b0, 5, 64'h1122334455_000000, "R1 buffer1 write/read");
        rd_buf(8'hD4, 24'h000007, 1'b1, 3, 64'h334455_0000000000, "R2 dummy-byte read");

        // R6 status when idle
        rd_status(8'h80, "R6 status idle");

        // R3 wrap in 512-byte mode on buffer 2
        wr_buf(8'h87, 24'h0001FE, 3, 64'hC1C2C3_0000000000);
        rd_buf(8'hD3, 24'h0001FE, 1'b0, 3, 64'hC1C2C3_0000000000, "R3 wrap 512 read");
        rd_buf(8'hD3, 24'h000000, 1'b0, 1, 64'hC3_00000000000000, "R3 wrap to byte 0");

        // R8 undefined opcode and truncated program
        short_cmd(8'h11, 4);
        #(4*HALF);
        chk(ready == 1'b1, "R8 undefined opcode ignored", int'(ready), 1);
        short_cmd(8'h83, 2);
        #(4*HALF);
        chk(ready == 1'b1, "R8 truncated program not started", int'(ready), 1);

        // R4 program buffer 1 to page 1 (page field starts at bit 9)
        busy_cnt = 0;
        short_cmd(8'h83, 0);
        spi_open();
        hdr(8'h83, 24'h000200);
        spi_close();
        chk(ready == 1'b0, "R4 ready low during program", int'(ready), 0);
        rd_status(8'h00, "R6 status busy");
        wr_buf(8'h87, 24'h000014, 2, 64'h5A5B_000000000000);
        rd_buf(8'hD3, 24'h000014, 1'b0, 2, 64'h5A5B_000000000000, "R7 other buffer usable while busy");
        wr_buf(8'h84, 24'h000005, 1, 64'hEE_00000000000000);
        spi_open();
        hdr(8'h55, 24'h000200);
        spi_close();
        chk(ready == 1'b0, "R7 still inside program window", int'(ready), 0);
        wait_ready();
        chk(busy_cnt == PROG, "R4 program busy length", busy_cnt, PROG);
        rd_buf(8'hD1, 24'h000005, 1'b0, 1, 64'h11_00000000000000, "R7 locked buffer write ignored");
        rd_buf(8'hD3, 24'h000014, 1'b0, 2, 64'h5A5B_000000000000, "R7 transfer while busy ignored");

        // R5 transfer page 1 into buffer 2
        busy_cnt = 0;
        spi_open();
        hdr(8'h55, 24'h000200);
        spi_close();
        wait_ready();
        chk(busy_cnt == XFER, "R5 transfer busy length", busy_cnt, XFER);
        rd_buf(8'hD6, 24'h000005, 1'b1, 5, 64'h1122334455_000000, "R5 page copied into buffer 2");

        // R9 528-byte pages: wrap at 527, page field starts at bit 10
        page_ext = 1'b1;
        wr_buf(8'h84, 24'h00020E, 3, 64'hA1A2A3_0000000000);
        rd_buf(8'hD1, 24'h00020E, 1'b0, 3, 64'hA1A2A3_0000000000, "R9 528 byte positions");
        rd_buf(8'hD1, 24'h000000, 1'b0, 1, 64'hA3_00000000000000, "R3 wrap after byte 527");
        spi_open();
        hdr(8'h83, 24'h000800);
        spi_close();
        wait_ready();
        spi_open();
        hdr(8'h55, 24'h000800);
        spi_close();
        wait_ready();
        rd_buf(8'hD3, 24'h00020E, 1'b0, 3, 64'hA1A2A3_0000000000, "R9 page 2 round trip");

        // R2 clock mode 3
        cpol = 1'b1;
        sck  = 1'b1;
        #(4*HALF);
        rd_buf(8'hD4, 24'h00020F, 1'b1, 2, 64'hA2A3_000000000000, "R2 mode 3 read");
        rd_status(8'h80, "R6 status mode 3");

        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule